// File: doc/BRIEF.md
# Reorder Buffer with Deferred Fault Commit

This block keeps in-flight instructions in program order inside a 16-slot circular buffer. Dispatch claims the slot at the tail and receives its index. An execution unit later marks that slot finished and hands over a result value and a fault bit. The oldest finished instructions then leave from the head, up to two per cycle, and their results go into an architectural register file that the block owns and that has a read port.

A fault found during execution stays in the slot and has no effect until that slot becomes the oldest instruction. At that point the block emits a one-cycle redirect with the slot index and the instruction address. It does not write the faulting result, and it empties the whole buffer. A branch misprediction names the slot of the branch. Every younger slot is dropped, so a fault held in a dropped slot is never reported.

Top module: `rob_top`

## Requirements
- R1: After synchronous reset, occupancy is 0, full is low, ret_count is 0, redirect is low and every architectural register reads 0.
- R2: A dispatch is accepted when disp_valid is high, full is low, and neither a live mispredict nor a redirect is present in the same cycle. It fills the slot shown on disp_idx (the tail), and the tail and occupancy each advance by one at that edge.
- R3: full is high exactly when occupancy equals 16. A dispatch offered while full is dropped and leaves occupancy at 16.
- R4: A writeback to a live slot (index minus head, modulo 16, smaller than occupancy) marks that slot finished with its data and fault bit. A writeback to a slot that is not live is ignored.
- R5: Retirement is in order from the head. Slot head+k retires in a cycle only if every older candidate in that cycle retired, it is finished and it has no fault. Its result reaches the register file at that cycle's edge when it has a destination.
- R6: A fault produces no output at writeback. redirect rises for a single cycle only when the head slot is finished and faulting, with redirect_idx equal to the head index and redirect_pc equal to that slot's dispatched address. The faulting result is never written.
- R7: In a redirect cycle nothing retires, any dispatch is dropped, and occupancy is 0 after that edge.
- R8: A mispredict naming a live slot m sets the tail to m+1 and drops every younger slot. A dispatch in the same cycle is dropped. Slots up to and including m may still retire in that cycle.
- R9: A fault held in a slot dropped by a mispredict never produces a redirect.
- R10: When two retiring slots in one cycle write the same register, the younger value remains.
- R11: ret_count gives the number of slots retiring in the current cycle (0, 1 or 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | 32 | Instruction address of dispatched instruction |
| disp_dest | input | 5 | Destination register |
| disp_has_dest | input | 1 | Instruction writes a register |
| disp_idx | output | 4 | Slot given to a dispatch this cycle (tail) |
| full | output | 1 | Buffer holds 16 live slots |
| wb_valid | input | 1 | Writeback request |
| wb_idx | input | 4 | Slot being completed |
| wb_data | input | 32 | Result value |
| wb_fault | input | 1 | Execution raised a fault |
| mp_valid | input | 1 | Branch misprediction |
| mp_idx | input | 4 | Slot of mispredicted branch |
| arf_rd_addr | input | 5 | Register file read address |
| arf_rd_data | output | 32 | Register file read data |
| ret_count | output | 2 | Slots retiring this cycle |
| redirect | output | 1 | Fault redirect pulse |
| redirect_idx | output | 4 | Slot of the faulting instruction |
| redirect_pc | output | 32 | Address of the faulting instruction |
| occupancy | output | 5 | Number of live slots |

## Verification
disp_idx, full, occupancy, ret_count and the three redirect outputs are combinational functions of registered state and of the mispredict inputs of the current cycle. The bench therefore drives inputs just after a falling edge and compares these outputs one time unit later, inside the same cycle. A writeback or dispatch becomes visible in these outputs only in the cycle after its edge. A retirement shows in arf_rd_data in the cycle after the retire cycle. A reference model steps once per cycle on the same inputs, and the directed cases for full, mispredict and fault put each expected value in the cycle derived above.

// File: rtl/rob_pkg.sv
package rob_pkg;
    parameter int ROB_DEPTH = 16;
    parameter int RET_W     = 2;
    parameter int DATA_W    = 32;
    parameter int PC_W      = 32;
    parameter int NUM_AREGS = 32;

    localparam int IDX_W  = $clog2(ROB_DEPTH);
    localparam int CNT_W  = IDX_W + 1;
    localparam int RN_W   = $clog2(RET_W + 1);
    localparam int AREG_W = $clog2(NUM_AREGS);

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [RN_W-1:0]   rn_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [AREG_W-1:0] areg_t;

    typedef struct packed {
        pc_t   pc;
        areg_t dest;
        logic  has_dest;
        logic  done;
        logic  fault;
        data_t value;
    } slot_t;

    // distance of a slot from the head, in program order (depth is a power of two)
    function automatic cnt_t slot_age(idx_t pos, idx_t head);
        idx_t d;
        d = pos - head;
        return {1'b0, d};
    endfunction
endpackage

// File: rtl/rob_slots.sv
module rob_slots
    import rob_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     alloc_en,
    input  idx_t                     alloc_idx,
    input  pc_t                      alloc_pc,
    input  areg_t                    alloc_dest,
    input  logic                     alloc_has_dest,
    input  logic                     wb_en,
    input  idx_t                     wb_idx,
    input  data_t                    wb_data,
    input  logic                     wb_fault,
    input  idx_t                     base_idx,
    output pc_t                      head_pc,
    output logic  [RET_W-1:0]        win_done,
    output logic  [RET_W-1:0]        win_fault,
    output logic  [RET_W-1:0]        win_has_dest,
    output areg_t [RET_W-1:0]        win_dest,
    output data_t [RET_W-1:0]        win_value
);
    slot_t mem [ROB_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROB_DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (alloc_en) begin
                mem[alloc_idx] <= '{pc: alloc_pc, dest: alloc_dest, has_dest: alloc_has_dest,
                                   done: 1'b0, fault: 1'b0, value: '0};
            end
            if (wb_en) begin
                mem[wb_idx].done  <= 1'b1;
                mem[wb_idx].fault <= wb_fault;
                mem[wb_idx].value <= wb_data;
            end
        end
    end

    assign head_pc = mem[base_idx].pc;

    for (genvar k = 0; k < RET_W; k++) begin : g_window
        slot_t s;
        assign s               = mem[base_idx + idx_t'(k)];
        assign win_done[k]     = s.done;
        assign win_fault[k]    = s.fault;
        assign win_has_dest[k] = s.has_dest;
        assign win_dest[k]     = s.dest;
        assign win_value[k]    = s.value;
    end

    // a fresh slot can never be a live writeback target in the same cycle (R4)
    assert_alloc_wb_apart_R4: assert property (@(posedge clk) disable iff (rst)
        !(alloc_en && wb_en && (alloc_idx == wb_idx)));
endmodule

// File: rtl/rob_retire.sv
module rob_retire
    import rob_pkg::*;
(
    input  logic [RET_W-1:0] win_done,
    input  logic [RET_W-1:0] win_fault,
    input  cnt_t             limit,
    output rn_t              n_ret,
    output logic             fault_fire
);
    logic go;

    always_comb begin
        fault_fire = (limit != '0) && win_done[0] && win_fault[0];
        n_ret      = '0;
        go         = !fault_fire;
        for (int k = 0; k < RET_W; k++) begin
            if (go && (cnt_t'(k) < limit) && win_done[k] && !win_fault[k]) begin
                n_ret = n_ret + rn_t'(1);
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rob_arf.sv
module rob_arf
    import rob_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic  [RET_W-1:0]    we,
    input  areg_t [RET_W-1:0]    waddr,
    input  data_t [RET_W-1:0]    wdata,
    input  areg_t                raddr,
    output data_t                rdata
);
    data_t regs [NUM_AREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_AREGS; i++) begin
                regs[i] <= '0;
            end
        end else begin
            // ascending order: the younger port overrides an older one
            for (int k = 0; k < RET_W; k++) begin
                if (we[k]) begin
                    regs[waddr[k]] <= wdata[k];
                end
            end
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/rob_top.sv
module rob_top
    import rob_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      disp_valid,
    input  logic [PC_W-1:0]           disp_pc,
    input  logic [AREG_W-1:0]         disp_dest,
    input  logic                      disp_has_dest,
    output logic [IDX_W-1:0]          disp_idx,
    output logic                      full,
    input  logic                      wb_valid,
    input  logic [IDX_W-1:0]          wb_idx,
    input  logic [DATA_W-1:0]         wb_data,
    input  logic                      wb_fault,
    input  logic                      mp_valid,
    input  logic [IDX_W-1:0]          mp_idx,
    input  logic [AREG_W-1:0]         arf_rd_addr,
    output logic [DATA_W-1:0]         arf_rd_data,
    output logic [RN_W-1:0]           ret_count,
    output logic                      redirect,
    output logic [IDX_W-1:0]          redirect_idx,
    output logic [PC_W-1:0]           redirect_pc,
    output logic [CNT_W-1:0]          occupancy
);
    idx_t head_q, tail_q, head_d, tail_d;
    cnt_t cnt_q, cnt_d;

    cnt_t  mp_age, mp_len, limit;
    logic  mp_live, wb_live, alloc, fault_fire;
    rn_t   n_ret;

    pc_t                 head_pc;
    logic  [RET_W-1:0]   win_done, win_fault, win_has_dest, arf_we;
    areg_t [RET_W-1:0]   win_dest;
    data_t [RET_W-1:0]   win_value;

    // ---------------- liveness and control ----------------
    assign full    = (cnt_q == cnt_t'(ROB_DEPTH));
    assign mp_age  = slot_age(mp_idx, head_q);
    assign mp_live = mp_valid && (mp_age < cnt_q);
    assign mp_len  = mp_age + cnt_t'(1);
    assign limit   = mp_live ? mp_len : cnt_q;
    assign wb_live = wb_valid && (slot_age(wb_idx, head_q) < cnt_q);
    assign alloc   = disp_valid && !full && !mp_live && !fault_fire;

    rob_slots u_slots (
        .clk            (clk),
        .rst            (rst),
        .alloc_en       (alloc),
        .alloc_idx      (tail_q),
        .alloc_pc       (disp_pc),
        .alloc_dest     (disp_dest),
        .alloc_has_dest (disp_has_dest),
        .wb_en          (wb_live),
        .wb_idx         (wb_idx),
        .wb_data        (wb_data),
        .wb_fault       (wb_fault),
        .base_idx       (head_q),
        .head_pc        (head_pc),
        .win_done       (win_done),
        .win_fault      (win_fault),
        .win_has_dest   (win_has_dest),
        .win_dest       (win_dest),
        .win_value      (win_value)
    );

    rob_retire u_retire (
        .win_done   (win_done),
        .win_fault  (win_fault),
        .limit      (limit),
        .n_ret      (n_ret),
        .fault_fire (fault_fire)
    );

    for (genvar k = 0; k < RET_W; k++) begin : g_arf_we
        assign arf_we[k] = (rn_t'(k) < n_ret) && win_has_dest[k];
    end

    rob_arf u_arf (
        .clk   (clk),
        .rst   (rst),
        .we    (arf_we),
        .waddr (win_dest),
        .wdata (win_value),
        .raddr (arf_rd_addr),
        .rdata (arf_rd_data)
    );

    // ---------------- pointer and count update ----------------
    always_comb begin
        head_d = head_q;
        tail_d = tail_q;
        cnt_d  = cnt_q;
        if (fault_fire) begin
            tail_d = head_q;
            cnt_d  = '0;
        end else if (mp_live) begin
            head_d = head_q + idx_t'(n_ret);
            tail_d = mp_idx + idx_t'(1);
            cnt_d  = mp_len - cnt_t'(n_ret);
        end else begin
            head_d = head_q + idx_t'(n_ret);
            tail_d = tail_q + idx_t'(alloc);
            cnt_d  = cnt_q - cnt_t'(n_ret) + cnt_t'(alloc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= head_d;
            tail_q <= tail_d;
            cnt_q  <= cnt_d;
        end
    end

    assign disp_idx     = tail_q;
    assign occupancy    = cnt_q;
    assign ret_count    = n_ret;
    assign redirect     = fault_fire;
    assign redirect_idx = head_q;
    assign redirect_pc  = head_pc;

    // ---------------- assertions ----------------
    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= cnt_t'(ROB_DEPTH));

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (full && !mp_live && !fault_fire && (n_ret == '0)) |=> full);

    assert_flush_all_R7: assert property (@(posedge clk) disable iff (rst)
        fault_fire |=> (occupancy == '0));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        fault_fire |=> !redirect);

    assert_mp_tail_R8: assert property (@(posedge clk) disable iff (rst)
        (mp_live && !fault_fire) |=> (disp_idx == $past(mp_idx) + idx_t'(1)));
endmodule

// File: tb/rob_top_tb.sv
module rob_top_tb;
    import rob_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = ROB_DEPTH;
    localparam int RAND_CYCLES = 4000;

    logic clk = 1'b0;
    logic rst;
    logic disp_valid, disp_has_dest, wb_valid, wb_fault, mp_valid;
    logic [PC_W-1:0]   disp_pc;
    logic [AREG_W-1:0] disp_dest, arf_rd_addr;
    logic [IDX_W-1:0]  wb_idx, mp_idx, disp_idx, redirect_idx;
    logic [DATA_W-1:0] wb_data, arf_rd_data;
    logic [RN_W-1:0]   ret_count;
    logic [PC_W-1:0]   redirect_pc;
    logic [CNT_W-1:0]  occupancy;
    logic full, redirect;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_top u_dut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_dest(disp_dest),
        .disp_has_dest(disp_has_dest), .disp_idx(disp_idx), .full(full),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .wb_fault(wb_fault),
        .mp_valid(mp_valid), .mp_idx(mp_idx),
        .arf_rd_addr(arf_rd_addr), .arf_rd_data(arf_rd_data),
        .ret_count(ret_count), .redirect(redirect), .redirect_idx(redirect_idx),
        .redirect_pc(redirect_pc), .occupancy(occupancy)
    );

    // ---------------- reference model ----------------
    int          m_head, m_tail, m_cnt;
    logic [31:0] m_pc   [DEPTH];
    int          m_dest [DEPTH];
    logic        m_hd   [DEPTH];
    logic        m_done [DEPTH];
    logic        m_flt  [DEPTH];
    logic [31:0] m_val  [DEPTH];
    logic [31:0] m_arf  [NUM_AREGS];

    int n_cmp = 0;
    int n_bad = 0;
    int redirect_seen = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int age(input int pos);
        return (pos - m_head) & (DEPTH - 1);
    endfunction

    task automatic model_reset();
        m_head = 0; m_tail = 0; m_cnt = 0;
        for (int i = 0; i < DEPTH; i++) begin
            m_pc[i] = '0; m_dest[i] = 0; m_hd[i] = 0; m_done[i] = 0; m_flt[i] = 0; m_val[i] = '0;
        end
        for (int i = 0; i < NUM_AREGS; i++) m_arf[i] = '0;
    endtask

    // compare all outputs against the model, then advance the model by one edge
    task automatic sample();
        int lim, nret, len, p;
        bit mpl, ffire, alloc;
        #1;
        mpl = mp_valid && (age(int'(mp_idx)) < m_cnt);
        len = age(int'(mp_idx)) + 1;
        lim = mpl ? len : m_cnt;
        ffire = (lim > 0) && m_done[m_head] && m_flt[m_head];
        nret = 0;
        if (!ffire) begin
            for (int k = 0; k < RET_W; k++) begin
                p = (m_head + k) & (DEPTH - 1);
                if (k < lim && m_done[p] && !m_flt[p]) nret++;
                else break;
            end
        end
        chk("R2", "occupancy", 64'(occupancy), 64'(m_cnt));
        chk("R2", "disp_idx", 64'(disp_idx), 64'(m_tail));
        chk("R3", "full", 64'(full), 64'(m_cnt == DEPTH));
        chk("R11", "ret_count", 64'(ret_count), 64'(nret));
        chk("R6", "redirect", 64'(redirect), 64'(ffire));
        if (ffire) begin
            chk("R6", "redirect_idx", 64'(redirect_idx), 64'(m_head));
            chk("R6", "redirect_pc", 64'(redirect_pc), 64'(m_pc[m_head]));
        end
        chk("R5", "arf_rd_data", 64'(arf_rd_data), 64'(m_arf[arf_rd_addr]));
        if (redirect === 1'b1) redirect_seen++;
        if (rst) begin
            model_reset();
        end else begin
            alloc = disp_valid && (m_cnt != DEPTH) && !mpl && !ffire;
            for (int k = 0; k < nret; k++) begin
                p = (m_head + k) & (DEPTH - 1);
                if (m_hd[p]) m_arf[m_dest[p]] = m_val[p];
            end
            if (wb_valid && age(int'(wb_idx)) < m_cnt) begin
                m_done[wb_idx] = 1; m_flt[wb_idx] = wb_fault; m_val[wb_idx] = wb_data;
            end
            if (alloc) begin
                m_pc[m_tail] = disp_pc; m_dest[m_tail] = int'(disp_dest); m_hd[m_tail] = disp_has_dest;
                m_done[m_tail] = 0; m_flt[m_tail] = 0; m_val[m_tail] = '0;
            end
            if (ffire) begin
                m_tail = m_head; m_cnt = 0;
            end else if (mpl) begin
                m_head = (m_head + nret) & (DEPTH - 1);
                m_tail = (int'(mp_idx) + 1) & (DEPTH - 1);
                m_cnt = len - nret;
            end else begin
                m_head = (m_head + nret) & (DEPTH - 1);
                m_tail = (m_tail + int'(alloc)) & (DEPTH - 1);
                m_cnt = m_cnt - nret + int'(alloc);
            end
        end
    endtask

    task automatic advance();
        @(negedge clk);
    endtask

    task automatic idle();
        disp_valid = 0; wb_valid = 0; mp_valid = 0; wb_fault = 0;
    endtask

    task automatic do_wb(input int idx, input logic [31:0] d, input logic f);
        idle(); wb_valid = 1; wb_idx = IDX_W'(idx); wb_data = d; wb_fault = f;
    endtask

    task automatic gen_random();
        int off;
        idle();
        disp_valid = ($urandom % 3) != 0;
        disp_pc = $urandom; disp_dest = AREG_W'($urandom); disp_has_dest = ($urandom % 10) != 0;
        arf_rd_addr = AREG_W'($urandom);
        if (m_cnt > 0 && ($urandom % 10) < 7) begin
            off = $urandom % m_cnt;
            wb_valid = 1; wb_idx = IDX_W'(m_head + off);
        end else if (m_cnt < DEPTH && ($urandom % 2) == 0) begin
            wb_valid = 1; wb_idx = IDX_W'(m_tail);   // not live: ignored (R4)
        end
        wb_data = $urandom; wb_fault = ($urandom % 12) == 0;
        if (m_cnt > 0 && ($urandom % 25) == 0) begin
            mp_valid = 1; mp_idx = IDX_W'(m_head + ($urandom % m_cnt));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0b1e));
        idle(); disp_pc = '0; disp_dest = '0; disp_has_dest = 0; wb_idx = '0; wb_data = '0;
        mp_idx = '0; arf_rd_addr = '0; rst = 1;
        model_reset();
        advance();
        repeat (3) begin sample(); advance(); end
        rst = 0;

        // R1: reset state
        idle(); arf_rd_addr = 5'd5;
        sample();
        chk("R1", "occupancy", 64'(occupancy), 0);
        chk("R1", "full", 64'(full), 0);
        chk("R1", "redirect", 64'(redirect), 0);
        chk("R1", "ret_count", 64'(ret_count), 0);
        chk("R1", "arf", 64'(arf_rd_data), 0);
        advance();

        // R2/R3: fill all 16 slots; slots 0..3 target register 7
        for (int i = 0; i < DEPTH; i++) begin
            idle(); disp_valid = 1; disp_pc = 32'h1000 + 32'(4 * i);
            disp_dest = (i < 4) ? 5'd7 : AREG_W'(i); disp_has_dest = 1;
            sample();
            chk("R2", "disp_idx on fill", 64'(disp_idx), 64'(i));
            advance();
        end
        idle(); disp_valid = 1; disp_pc = 32'h9999;
        sample();
        chk("R3", "full at 16", 64'(full), 1);
        advance();
        idle(); sample();
        chk("R3", "dispatch while full dropped", 64'(occupancy), 16);
        advance();

        // R4/R5/R10: complete out of order, head last
        do_wb(1, 32'h1111, 0); sample();
        chk("R4", "no retire with head pending", 64'(ret_count), 0); advance();
        do_wb(2, 32'hAAAA, 0); sample(); advance();
        do_wb(3, 32'hBBBB, 0); sample(); advance();
        do_wb(0, 32'h0, 0); sample(); advance();
        idle(); sample();
        chk("R5", "two retire", 64'(ret_count), 2); advance();
        idle(); sample();
        chk("R10", "pair retire same dest", 64'(ret_count), 2); advance();
        idle(); arf_rd_addr = 5'd7; sample();
        chk("R10", "younger value kept", 64'(arf_rd_data), 32'hBBBB); advance();

        // R6/R8/R9: fault in slot 9, then mispredict at slot 5
        do_wb(9, 32'hDEAD, 1); sample();
        chk("R6", "no redirect at writeback", 64'(redirect), 0); advance();
        idle(); mp_valid = 1; mp_idx = 4'd5; disp_valid = 1; sample(); advance();
        do_wb(4, 32'h4444, 0); sample();
        chk("R8", "occupancy after squash", 64'(occupancy), 2);
        chk("R8", "tail after squash", 64'(disp_idx), 6); advance();
        do_wb(5, 32'h5555, 0);
        redirect_seen = 0;
        sample(); advance();
        repeat (4) begin idle(); sample(); advance(); end
        chk("R9", "squashed fault silent", 64'(redirect_seen), 0);
        do_wb(9, 32'h7777, 0); sample();
        chk("R4", "dead writeback ignored", 64'(ret_count), 0); advance();
        idle(); sample();
        chk("R4", "dead writeback ignored occ", 64'(occupancy), 0); advance();

        // R6/R7: slots 6,7,8; 7 faults
        for (int i = 0; i < 3; i++) begin
            idle(); disp_valid = 1; disp_pc = 32'h2000 + 32'(4 * i);
            disp_dest = AREG_W'(20 + i); disp_has_dest = 1;
            sample(); advance();
        end
        do_wb(7, 32'hBAD0, 1); sample(); advance();
        do_wb(8, 32'h0008, 0); sample(); advance();
        do_wb(6, 32'h0006, 0); sample(); advance();
        idle(); sample();
        chk("R5", "stop before faulting slot", 64'(ret_count), 1); advance();
        idle(); disp_valid = 1; sample();
        chk("R6", "redirect at head", 64'(redirect), 1);
        chk("R6", "redirect_idx", 64'(redirect_idx), 7);
        chk("R6", "redirect_pc", 64'(redirect_pc), 32'h2004);
        chk("R7", "nothing retires on fault", 64'(ret_count), 0);
        advance();
        idle(); arf_rd_addr = 5'd21; sample();
        chk("R7", "flushed", 64'(occupancy), 0);
        chk("R6", "fault result not written", 64'(arf_rd_data), 0);
        advance();

        // random phase
        for (int c = 0; c < RAND_CYCLES; c++) begin
            gen_random(); sample(); advance();
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule